// File: doc/BRIEF.md
# Boost Switch On-Time Calculator

This block works out how long the boost switch stays on in the next fixed-period pulse of a discontinuous-mode power-factor stage. A start strobe loads three unsigned 16-bit readings: the high-voltage rail reading, the rectified line reading and a gain word K. The gain word is set by a slow outer voltage loop. The block then runs a short sequential datapath. It adds a fixed diode offset to the rail reading and brings the line reading to rail units. It subtracts the two, clips the result at zero, scales it, and multiplies it by K. It divides by the output voltage and takes the integer square root.

Before the divide, the divisor is pre-scaled by powers of four until the quotient fits in 16 bits. The root is later shifted left once per pre-scale step, which restores the scale. The result is clamped to a maximum duty value and presented with a one-cycle done strobe. The full computation takes a few dozen clocks. This is far inside a 40 µs switching period at 25 kHz.

Top module: `boost_ontime_calc`

## Requirements
- R1: While reset is asserted and after it is released, `onTime` reads 0 and `done` reads 0 until a computation completes.
- R2: The effective output voltage is `(railRd + DIODE_DROP) mod 65536`. The scaled line voltage is `(lineRd * LINE_SCALE) >> 16`.
- R3: The difference is the effective output voltage minus the scaled line voltage, and it is forced to 0 when that is negative. It is shifted left 4 bits, keeping only the low 16 bits, and then multiplied by `gainK` to form a 32-bit numerator.
- R4: The divisor starts as the effective output voltage. It is multiplied by 4 while it is not greater than the upper 16 bits of the numerator, and the number of multiplications is counted.
- R5: The quotient is floor(numerator / scaled divisor), which always fits in 16 bits. Its floor square root is found as an 8-bit value, one bit per clock, from the most significant bit down.
- R6: The root is shifted left by the count of divisor scalings.
- R7: The shifted root is limited to `maxDuty`. `maxDuty` is sampled in the same cycle as the accepted start.
- R8: When the effective output voltage is 0, the result is `maxDuty`.
- R9: `done` is high for exactly one cycle per computation. `onTime` keeps its value from one `done` pulse to the next.
- R10: A start raised while a computation is in progress is ignored. The running computation finishes with its original inputs and produces a single `done`.
- R11: `done` rises no more than 40 clock cycles after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| railRd | input | 16 | High-voltage rail reading |
| lineRd | input | 16 | Rectified line reading |
| gainK | input | 16 | Proportionality gain K |
| maxDuty | input | 16 | Upper limit on the result |
| onTime | output | 16 | Clamped switch on-time |
| done | output | 1 | One-cycle strobe: onTime updated |

## Verification
A wrong count of divisor scalings shows up as an on-time that is off by a power of two. A fault in the divider or the root stage shows up as a value off by a few codes. Either error appears on the first `done` after the faulty step, no more than 40 cycles after start. A stuck or misrouted sequencer shows up in a different way: `done` never arrives, arrives late, or arrives twice. A start that leaks through while busy shows up as a result built from the second set of inputs. The bench compares every result against an independently computed model, including cases that force several scalings, clamping, a zero divisor and a clipped difference.

// File: rtl/boost_ontime_pkg.sv
package boost_ontime_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_DIV,
    ST_ROOT,
    ST_FINISH
  } calcStateT;

  typedef struct packed {
    logic load;
    logic normShift;
    logic divInit;
    logic divBit;
    logic rootBit;
    logic finish;
  } ctrlStrobeT;

endpackage

// File: rtl/boost_ontime_ctrl.sv
module boost_ontime_ctrl
  import boost_ontime_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               normDone,
  input  logic               divZero,
  output ctrlStrobeT         strb,
  output logic [$clog2(W/2)-1:0] rootIdx,
  output logic               busy
);

  localparam int HW  = W / 2;
  localparam int CW  = $clog2(W) + 1;
  localparam int RIW = $clog2(HW);

  calcStateT state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE:   strb.load = start;
      ST_NORM: begin
        if (!divZero) begin
          if (normDone) strb.divInit = 1'b1;
          else          strb.normShift = 1'b1;
        end
      end
      ST_DIV:    strb.divBit  = 1'b1;
      ST_ROOT:   strb.rootBit = 1'b1;
      ST_FINISH: strb.finish  = 1'b1;
      default:   strb = '0;
    endcase
  end

  assign rootIdx = RIW'(HW - 1) - iterCnt[RIW-1:0];
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          iterCnt <= '0;
          if (start) state <= ST_NORM;
        end
        ST_NORM: begin
          iterCnt <= '0;
          if (divZero)       state <= ST_FINISH;
          else if (normDone) state <= ST_DIV;
        end
        ST_DIV: begin
          if (iterCnt == CW'(W - 1)) begin
            iterCnt <= '0;
            state   <= ST_ROOT;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        ST_ROOT: begin
          if (iterCnt == CW'(HW - 1)) begin
            iterCnt <= '0;
            state   <= ST_FINISH;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boost_ontime_dp.sv
module boost_ontime_dp
  import boost_ontime_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [15:0] DIODE_DROP = 16'd12,
  parameter logic [15:0] LINE_SCALE = 16'd52000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strb,
  input  logic [$clog2(W/2)-1:0] rootIdx,
  input  logic [W-1:0]           railRd,
  input  logic [W-1:0]           lineRd,
  input  logic [W-1:0]           gainK,
  input  logic [W-1:0]           maxDuty,
  output logic                   normDone,
  output logic                   divZero,
  output logic [W-1:0]           onTime,
  output logic                   done
);

  localparam int HW = W / 2;
  localparam int DW = W + 4;
  localparam int CW = $clog2(W) + 1;

  // front end, evaluated combinationally from the port readings
  logic [W-1:0]   voNext;
  logic [2*W-1:0] lineProd;
  logic [W-1:0]   lineScaled;
  logic [W-1:0]   diffClip;
  logic [W-1:0]   diffSh;
  logic [2*W-1:0] prodNext;

  assign voNext     = railRd + W'(DIODE_DROP);
  assign lineProd   = (2*W)'(lineRd) * (2*W)'(LINE_SCALE);
  assign lineScaled = W'(lineProd >> W);
  assign diffClip   = (voNext > lineScaled) ? (voNext - lineScaled) : '0;
  assign diffSh     = W'({diffClip, 4'b0000});
  assign prodNext   = (2*W)'(diffSh) * (2*W)'(gainK);

  // working registers
  logic [W-1:0]   voReg;
  logic [2*W-1:0] prodReg;
  logic [W-1:0]   maxReg;
  logic [DW-1:0]  divReg;
  logic [CW-1:0]  shCnt;
  logic [DW:0]    remReg;
  logic [W-1:0]   numLo;
  logic [W-1:0]   quot;
  logic [HW-1:0]  rootReg;

  assign normDone = (DW'(prodReg[2*W-1:W]) < divReg);
  assign divZero  = (voReg == '0);

  // divider step
  logic [DW:0] remSh;
  logic        remGe;
  assign remSh = {remReg[DW-1:0], numLo[W-1]};
  assign remGe = (remSh >= {1'b0, divReg});

  // root step
  logic [HW-1:0] trial;
  logic [W-1:0]  trialSq;
  assign trial   = rootReg | (HW'(1) << rootIdx);
  assign trialSq = W'(trial) * W'(trial);

  // rescale and clamp
  logic [2*W-1:0] scaledRoot;
  logic [W-1:0]   clamped;
  assign scaledRoot = (2*W)'(rootReg) << shCnt;
  assign clamped    = (scaledRoot > (2*W)'(maxReg)) ? maxReg : scaledRoot[W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      voReg   <= '0;
      prodReg <= '0;
      maxReg  <= '0;
      divReg  <= '0;
      shCnt   <= '0;
      remReg  <= '0;
      numLo   <= '0;
      quot    <= '0;
      rootReg <= '0;
      onTime  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        voReg   <= voNext;
        prodReg <= prodNext;
        maxReg  <= maxDuty;
        divReg  <= DW'(voNext);
        shCnt   <= '0;
      end
      if (strb.normShift) begin
        divReg <= divReg << 2;
        shCnt  <= shCnt + 1'b1;
      end
      if (strb.divInit) begin
        remReg  <= (DW+1)'(prodReg[2*W-1:W]);
        numLo   <= prodReg[W-1:0];
        quot    <= '0;
        rootReg <= '0;
      end
      if (strb.divBit) begin
        remReg <= remGe ? (remSh - {1'b0, divReg}) : remSh;
        quot   <= {quot[W-2:0], remGe};
        numLo  <= numLo << 1;
      end
      if (strb.rootBit && (trialSq <= quot)) begin
        rootReg <= trial;
      end
      if (strb.finish) begin
        onTime <= divZero ? maxReg : clamped;
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/boost_ontime_calc.sv
module boost_ontime_calc
  import boost_ontime_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [15:0] DIODE_DROP = 16'd12,
  parameter logic [15:0] LINE_SCALE = 16'd52000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] railRd,
  input  logic [W-1:0] lineRd,
  input  logic [W-1:0] gainK,
  input  logic [W-1:0] maxDuty,
  output logic [W-1:0] onTime,
  output logic         done
);

  ctrlStrobeT strb;
  logic [$clog2(W/2)-1:0] rootIdx;
  logic normDone;
  logic divZero;
  logic busy;

  boost_ontime_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .normDone (normDone),
    .divZero  (divZero),
    .strb     (strb),
    .rootIdx  (rootIdx),
    .busy     (busy)
  );

  boost_ontime_dp #(
    .W          (W),
    .DIODE_DROP (DIODE_DROP),
    .LINE_SCALE (LINE_SCALE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rootIdx  (rootIdx),
    .railRd   (railRd),
    .lineRd   (lineRd),
    .gainK    (gainK),
    .maxDuty  (maxDuty),
    .normDone (normDone),
    .divZero  (divZero),
    .onTime   (onTime),
    .done     (done)
  );

endmodule

// File: rtl/boost_ontime_chk.sv
module boost_ontime_chk
  import boost_ontime_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input ctrlStrobeT   strb,
  input logic [W-1:0] maxDuty,
  input logic [W-1:0] onTime,
  input logic         done
);

  logic [W-1:0] capMax;
  logic [7:0]   latCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capMax <= '0;
      latCnt <= '0;
    end else begin
      if (start && !busy) begin
        capMax <= maxDuty;
        latCnt <= 8'd1;
      end else if (busy && latCnt != 8'hFF) begin
        latCnt <= latCnt + 1'b1;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(onTime));

  // R7
  clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (onTime <= capMax));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (latCnt <= 8'd40));

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !strb.load);

endmodule

bind boost_ontime_calc boost_ontime_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .strb    (strb),
  .maxDuty (maxDuty),
  .onTime  (onTime),
  .done    (done)
);

// File: tb/boost_ontime_calc_tb.sv
module boost_ontime_calc_tb;

  localparam logic [15:0] DIODE = 16'd12;
  localparam logic [15:0] LSCL  = 16'd52000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] railRd = '0;
  logic [15:0] lineRd = '0;
  logic [15:0] gainK = '0;
  logic [15:0] maxDuty = '0;
  logic [15:0] onTime;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  boost_ontime_calc #(.W(16), .DIODE_DROP(DIODE), .LINE_SCALE(LSCL)) u_dut (
    .clk (clk), .rstN (rstN), .start (start),
    .railRd (railRd), .lineRd (lineRd), .gainK (gainK), .maxDuty (maxDuty),
    .onTime (onTime), .done (done)
  );

  function automatic logic [15:0] refOnTime(input logic [15:0] r, l, k, m);
    longint vo, ls, df, ds, num, dv, q, rt, res;
    int cnt;
    vo = (longint'(r) + longint'(DIODE)) % 65536;
    if (vo == 0) return m;
    ls = (longint'(l) * longint'(LSCL)) / 65536;
    df = (vo > ls) ? vo - ls : 0;
    ds = (df * 16) % 65536;
    num = ds * longint'(k);
    dv = vo;
    cnt = 0;
    while ((num / 65536) >= dv) begin
      dv = dv * 4;
      cnt++;
    end
    q = num / dv;
    rt = 0;
    while (rt < 255 && (rt + 1) * (rt + 1) <= q) rt++;
    res = rt * (longint'(1) << cnt);
    if (res > longint'(m)) res = m;
    return res[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCase(input logic [15:0] r, l, k, m, input string req);
    logic [15:0] exp;
    int lat;
    exp = refOnTime(r, l, k, m);
    @(negedge clk);
    railRd = r; lineRd = l; gainK = k; maxDuty = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    // R11 latency bound
    check(lat <= 40, "R11", lat, 40);
    check(onTime == exp, req, onTime, exp);
    @(negedge clk);
    // R9 one-cycle strobe and held value
    check(!done, "R9", done, 0);
    check(onTime == exp, "R9", onTime, exp);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] expA;
    int doneCnt;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(onTime == 16'd0, "R1", onTime, 0);
    check(done == 1'b0, "R1", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(onTime == 16'd0 && !done, "R1", onTime, 0);

    // R3 clipped difference gives zero
    runCase(16'd1000, 16'd60000, 16'hFFFF, 16'hFFFF, "R3");
    // R4 R6 several divisor scalings
    runCase(16'd100, 16'd0, 16'hFFFF, 16'hFFFF, "R4_R6");
    // R7 clamp
    runCase(16'd100, 16'd0, 16'hFFFF, 16'd5, "R7");
    // R8 zero divisor
    runCase(16'd65536 - DIODE, 16'd0, 16'h1234, 16'd1234, "R8");
    // R3 truncating shift of a large difference
    runCase(16'hF000, 16'd0, 16'h8000, 16'hFFFF, "R3");
    // R2 line scaling near the crossover
    runCase(16'd40000, 16'd50000, 16'h4000, 16'hFFFF, "R2");
    // R5 small quotient, single-bit roots
    runCase(16'd300, 16'd0, 16'd1, 16'hFFFF, "R5");

    // R10 start while busy is ignored
    expA = refOnTime(16'd100, 16'd0, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    railRd = 16'd100; lineRd = 16'd0; gainK = 16'hFFFF; maxDuty = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    railRd = 16'd5000; lineRd = 16'd100; gainK = 16'd77; maxDuty = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    doneCnt = 0;
    for (int i = 0; i < 80; i++) begin
      if (done) begin
        doneCnt++;
        check(onTime == expA, "R10", onTime, expA);
      end
      @(negedge clk);
    end
    check(doneCnt == 1, "R10", doneCnt, 1);

    // R2 R3 R4 R5 R6 R7 constrained random
    for (int i = 0; i < 200; i++) begin
      logic [15:0] r, l, k, m;
      r = 16'($urandom);
      l = (i % 3 == 0) ? 16'($urandom_range(0, 4000)) : 16'($urandom);
      k = 16'($urandom);
      m = (i % 2 == 0) ? 16'hFFFF : 16'($urandom_range(1, 600));
      runCase(r, l, k, m, "R5_random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule